// File: doc/BRIEF.md
# Power Mode and Wake-up Controller

This block keeps track of the operating mode of a small 8-bit controller core. It decodes a two-bit mode field together with a one-cycle sleep-instruction strobe. From these it selects one of four modes: sleep, idle, green (slow clock) or normal. It drives the clock-gating enables for the core and its peripherals. It also drives a select line that moves the core onto the slow oscillator.

The block watches four kinds of wake-up source:
- a timer overflow,
- a watchdog time-out,
- falling edges on a group of general port pins,
- edges on four dedicated wake pins.

The first dedicated pin has a programmable edge. The other dedicated pins and the whole port group react to falling edges only. Port pins pass through a two-flop synchronizer, and a registered previous value turns each edge into a one-cycle event.

How an event is handled depends on the current mode. It can become a reset request, a resume at the next instruction, a resume with an interrupt, or an interrupt alone.

The state machine has four states:

| State | Code |
|---|---|
| SLEEP | 0 |
| IDLE | 1 |
| GREEN | 2 |
| NORMAL | 3 |

Its transitions are:
- **RUN_SELECT**: NORMAL↔GREEN, following `mode_sel[0]`.
- **ENTER_SLEEP**: run state → SLEEP.
- **ENTER_IDLE**: run state → IDLE.
- **IDLE_RESUME**: IDLE → run state.
- **WDT_RESET**: run state → NORMAL, with a reset request.
- **SLEEP_RESET**: SLEEP → NORMAL, with a reset request.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset the mode output is NORMAL (code 3), and `irq_req` and `rst_req` are low.
- R2: In a run state with `sleep_cmd` low, the next state is NORMAL when `mode_sel[0]`=1 and GREEN when `mode_sel[0]`=0.
- R3: `sleep_cmd` with `mode_sel`=2'b00 enters SLEEP, and with `mode_sel`=2'b10 enters IDLE, one cycle later. With `mode_sel[0]`=1 the strobe is ignored and R2 applies. SLEEP and IDLE persist while no wake event occurs.
- R4: `cpu_clk_en` is high only in NORMAL and GREEN. `periph_clk_en` is low only in SLEEP. `slow_clk_sel` is high only in GREEN.
- R5: Wake pin 0 reacts to a rising edge when `p7_rise_sel`=1 and to a falling edge when it is 0. Wake pins 1 to 3 and every port pin react to falling edges only. A pin change made before clock edge k produces its response after edge k+2.
- R6: Wake pin i counts only when `p7_wake_en[i]` and `gie` are both set. The port group counts only when `p9_wake_en` and `gie` are both set.
- R7: In NORMAL or GREEN, a timer overflow or a counted port event with `gie` set gives a one-cycle `irq_req` and leaves the mode unchanged. With `gie` clear, a timer overflow gives no request.
- R8: In NORMAL or GREEN, a watchdog time-out with `wdt_en` set gives a one-cycle `rst_req`, and the mode reads NORMAL in that cycle.
- R9: In IDLE, a timer overflow, a counted port event or an enabled watchdog time-out resumes into the run state chosen by `mode_sel[0]`. `irq_req` accompanies the resume when `gie` is set and the source was the timer or a port. A watchdog resume carries no interrupt.
- R10: In SLEEP, an enabled watchdog time-out or a counted port event gives `rst_req`, and the mode is NORMAL in that cycle. A timer overflow in SLEEP is ignored.
- R11: With `wdt_en` clear, `wdt_tmo` has no effect in any mode.
- R12: `irq_req` and `rst_req` are never high together. When a watchdog reset coincides with an interrupt source, the reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock for the controller and synchronizers |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode field; bit 0 selects normal (1) or green (0) |
| sleep_cmd | input | 1 | One-cycle strobe from the sleep instruction |
| gie | input | 1 | Global interrupt enable |
| wdt_en | input | 1 | Watchdog effect enable |
| tmr_ovf | input | 1 | Timer overflow pulse |
| wdt_tmo | input | 1 | Watchdog time-out pulse |
| p7_pins | input | P7_W | Dedicated wake pins, asynchronous |
| p7_wake_en | input | P7_W | Per-pin wake enables |
| p7_rise_sel | input | 1 | Wake pin 0 polarity: 1 = rising, 0 = falling |
| p9_pins | input | P9_W | Port group pins, asynchronous |
| p9_wake_en | input | 1 | Port group wake enable |
| mode_o | output | 2 | Current state code |
| cpu_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| slow_clk_sel | output | 1 | Selects the slow oscillator |
| irq_req | output | 1 | One-cycle interrupt request |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions assume the following about the inputs:
- `sleep_cmd`, `tmr_ovf` and `wdt_tmo` are pulses in the clock domain.
- The configuration inputs (`gie`, `wdt_en`, the enables and the polarity) stay still while a pin event travels through the synchronizer.

The stimulus changes configuration only while `gie` is low, and waits for any old edges to drain before enabling a trial. It drives each source once per trial, with a quiet window around it. Every pin is left at its idle-high level between trials, so that no stray edge leaks into the next combination of mode, source, polarity and enable.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

    typedef enum logic [1:0] {
        PM_SLEEP  = 2'd0,
        PM_IDLE   = 2'd1,
        PM_GREEN  = 2'd2,
        PM_NORMAL = 2'd3
    } pm_state_e;

    localparam logic [1:0] SEL_SLEEP = 2'b00;
    localparam logic [1:0] SEL_IDLE  = 2'b10;

    function automatic pm_state_e run_of(input logic sel0);
        return sel0 ? PM_NORMAL : PM_GREEN;
    endfunction

endpackage

// File: rtl/pwr_edge_det.sv
module pwr_edge_det #(
    parameter int W     = 4,
    parameter int SYNC  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] rise_mask,
    output logic [W-1:0] evt
);
    localparam int LAST = SYNC - 1;

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [SYNC-1:0] chain;
        logic            prev;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
                prev  <= 1'b1;
            end else begin
                chain <= {chain[SYNC-2:0], pins[g]};
                prev  <= chain[LAST];
            end
        end

        // rising when masked, falling otherwise
        assign evt[g] = rise_mask[g] ? (chain[LAST] & ~prev)
                                     : (~chain[LAST] & prev);
    end

endmodule

// File: rtl/pwr_wake_src.sv
module pwr_wake_src #(
    parameter int P7_W = 4,
    parameter int P9_W = 8
) (
    input  logic            gie,
    input  logic            wdt_en,
    input  logic            tmr_ovf,
    input  logic            wdt_tmo,
    input  logic [P7_W-1:0] p7_evt,
    input  logic [P7_W-1:0] p7_wake_en,
    input  logic [P9_W-1:0] p9_evt,
    input  logic            p9_wake_en,
    output logic            tmr_evt,
    output logic            wdt_evt,
    output logic            port_evt
);
    logic p7_hit;
    logic p9_hit;

    always_comb begin
        p7_hit   = |(p7_evt & p7_wake_en);
        p9_hit   = p9_wake_en & (|p9_evt);
        port_evt = gie & (p7_hit | p9_hit);
        wdt_evt  = wdt_en & wdt_tmo;
        tmr_evt  = tmr_ovf;
    end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       sleep_cmd,
    input  logic       gie,
    input  logic       tmr_evt,
    input  logic       wdt_evt,
    input  logic       port_evt,
    output pm_state_e  state,
    output logic       irq_req,
    output logic       rst_req,
    output logic       cpu_clk_en,
    output logic       periph_clk_en,
    output logic       slow_clk_sel
);
    pm_state_e nxt;
    pm_state_e run_tgt;
    logic      irq_nx;
    logic      rst_nx;
    logic      int_src;

    always_comb begin
        int_src = tmr_evt | port_evt;
        run_tgt = run_of(mode_sel[0]);
        if (sleep_cmd && mode_sel == SEL_SLEEP)     run_tgt = PM_SLEEP;
        else if (sleep_cmd && mode_sel == SEL_IDLE) run_tgt = PM_IDLE;
    end

    always_comb begin
        nxt    = state;
        irq_nx = 1'b0;
        rst_nx = 1'b0;
        unique case (state)
            PM_NORMAL, PM_GREEN: begin
                if (wdt_evt) begin              // WDT_RESET
                    rst_nx = 1'b1;
                    nxt    = PM_NORMAL;
                end else begin                  // RUN_SELECT / ENTER_*
                    irq_nx = gie & int_src;
                    nxt    = run_tgt;
                end
            end
            PM_IDLE: begin
                if (int_src || wdt_evt) begin   // IDLE_RESUME
                    irq_nx = gie & int_src;
                    nxt    = run_of(mode_sel[0]);
                end
            end
            PM_SLEEP: begin
                if (wdt_evt || port_evt) begin  // SLEEP_RESET
                    rst_nx = 1'b1;
                    nxt    = PM_NORMAL;
                end
            end
            default: nxt = PM_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= PM_NORMAL;
            irq_req <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            state   <= nxt;
            irq_req <= irq_nx;
            rst_req <= rst_nx;
        end
    end

    always_comb begin
        cpu_clk_en    = 1'b0;
        periph_clk_en = 1'b1;
        slow_clk_sel  = 1'b0;
        unique case (state)
            PM_NORMAL: cpu_clk_en = 1'b1;
            PM_GREEN: begin
                cpu_clk_en   = 1'b1;
                slow_clk_sel = 1'b1;
            end
            PM_IDLE:  cpu_clk_en = 1'b0;
            PM_SLEEP: periph_clk_en = 1'b0;
            default:  cpu_clk_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int P7_W = 4,
    parameter int P9_W = 8,
    parameter int SYNC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_sel,
    input  logic            sleep_cmd,
    input  logic            gie,
    input  logic            wdt_en,
    input  logic            tmr_ovf,
    input  logic            wdt_tmo,
    input  logic [P7_W-1:0] p7_pins,
    input  logic [P7_W-1:0] p7_wake_en,
    input  logic            p7_rise_sel,
    input  logic [P9_W-1:0] p9_pins,
    input  logic            p9_wake_en,
    output logic [1:0]      mode_o,
    output logic            cpu_clk_en,
    output logic            periph_clk_en,
    output logic            slow_clk_sel,
    output logic            irq_req,
    output logic            rst_req
);
    localparam int P7_PAD = P7_W - 1;

    logic [P7_W-1:0] p7_evt;
    logic [P9_W-1:0] p9_evt;
    logic [P7_W-1:0] p7_rise;
    logic            tmr_evt;
    logic            wdt_evt;
    logic            port_evt;
    pm_state_e       state;

    assign p7_rise = {{P7_PAD{1'b0}}, p7_rise_sel};

    pwr_edge_det #(.W(P7_W), .SYNC(SYNC)) u_p7_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      (p7_pins),
        .rise_mask (p7_rise),
        .evt       (p7_evt)
    );

    pwr_edge_det #(.W(P9_W), .SYNC(SYNC)) u_p9_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      (p9_pins),
        .rise_mask ({P9_W{1'b0}}),
        .evt       (p9_evt)
    );

    pwr_wake_src #(.P7_W(P7_W), .P9_W(P9_W)) u_src (
        .gie        (gie),
        .wdt_en     (wdt_en),
        .tmr_ovf    (tmr_ovf),
        .wdt_tmo    (wdt_tmo),
        .p7_evt     (p7_evt),
        .p7_wake_en (p7_wake_en),
        .p9_evt     (p9_evt),
        .p9_wake_en (p9_wake_en),
        .tmr_evt    (tmr_evt),
        .wdt_evt    (wdt_evt),
        .port_evt   (port_evt)
    );

    pwr_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_sel      (mode_sel),
        .sleep_cmd     (sleep_cmd),
        .gie           (gie),
        .tmr_evt       (tmr_evt),
        .wdt_evt       (wdt_evt),
        .port_evt      (port_evt),
        .state         (state),
        .irq_req       (irq_req),
        .rst_req       (rst_req),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en),
        .slow_clk_sel  (slow_clk_sel)
    );

    assign mode_o = state;

endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       sleep_cmd,
    input logic       wdt_en,
    input logic [1:0] mode_o,
    input logic       irq_req,
    input logic       rst_req
);
    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_req && rst_req));

    p_rst_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> mode_o == 2'd3);

    p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |=> !irq_req);

    p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && $past(mode_o) != 2'd0)
            |-> $past(sleep_cmd && mode_sel == 2'b00));

    p_idle_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == 2'd1 && mode_o != 2'd1) |-> mode_o[1]);

    p_wdt_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o[1]) && !$past(wdt_en)) |-> !rst_req);

endmodule

bind pwr_wake_ctrl pwr_wake_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .sleep_cmd (sleep_cmd),
    .wdt_en    (wdt_en),
    .mode_o    (mode_o),
    .irq_req   (irq_req),
    .rst_req   (rst_req)
);

// File: tb/pwr_wake_ctrl_bench.sv
module pwr_wake_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P7W = 4;
    localparam int P9W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     mode_sel = 2'b11;
    logic           sleep_cmd = 1'b0;
    logic           gie = 1'b0;
    logic           wdt_en = 1'b0;
    logic           tmr_ovf = 1'b0;
    logic           wdt_tmo = 1'b0;
    logic [P7W-1:0] p7_pins = '1;
    logic [P7W-1:0] p7_wake_en = '0;
    logic           p7_rise_sel = 1'b0;
    logic [P9W-1:0] p9_pins = '1;
    logic           p9_wake_en = 1'b0;
    logic [1:0]     mode_o;
    logic           cpu_clk_en, periph_clk_en, slow_clk_sel, irq_req, rst_req;

    int checks = 0;
    int fails  = 0;
    int irq_n, rst_cnt, irq_at, rst_mode, both;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_wake_ctrl #(.P7_W(P7W), .P9_W(P9W)) u_pwr_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_cmd(sleep_cmd),
        .gie(gie), .wdt_en(wdt_en), .tmr_ovf(tmr_ovf), .wdt_tmo(wdt_tmo),
        .p7_pins(p7_pins), .p7_wake_en(p7_wake_en), .p7_rise_sel(p7_rise_sel),
        .p9_pins(p9_pins), .p9_wake_en(p9_wake_en), .mode_o(mode_o),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .slow_clk_sel(slow_clk_sel), .irq_req(irq_req), .rst_req(rst_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        mode_sel = 2'b11; sleep_cmd = 0; gie = 0; wdt_en = 0; tmr_ovf = 0;
        wdt_tmo = 0; p7_pins = '1; p7_wake_en = '0; p7_rise_sel = 0;
        p9_pins = '1; p9_wake_en = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic enter(input logic [1:0] sel, input logic slp);
        mode_sel = sel; sleep_cmd = slp;
        @(negedge clk);
        sleep_cmd = 0;
    endtask

    task automatic observe(input int n);
        irq_n = 0; rst_cnt = 0; irq_at = 0; rst_mode = -1; both = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (i == 1) begin tmr_ovf = 0; wdt_tmo = 0; sleep_cmd = 0; end
            if (irq_req) begin irq_n++; if (irq_at == 0) irq_at = i; end
            if (rst_req) begin rst_cnt++; rst_mode = int'(mode_o); end
            if (irq_req && rst_req) both++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R1 R4: reset state
        do_reset();
        chk("R1 mode", int'(mode_o), 3);
        chk("R1 irq", int'(irq_req), 0);
        chk("R1 rst", int'(rst_req), 0);
        chk("R4 cpu_clk", int'(cpu_clk_en), 1);
        chk("R4 slow", int'(slow_clk_sel), 0);

        // R2 R3 R4: mode field x sleep strobe sweep
        for (int sel = 0; sel < 4; sel++) begin
            for (int slp = 0; slp < 2; slp++) begin
                int exp;
                do_reset();
                enter(2'(sel), 1'(slp));
                if (slp == 1 && sel == 0) exp = 0;
                else if (slp == 1 && sel == 2) exp = 1;
                else exp = (sel % 2 == 1) ? 3 : 2;
                chk(slp ? "R3 mode" : "R2 mode", int'(mode_o), exp);
                chk("R4 cpu_clk", int'(cpu_clk_en), int'(exp >= 2));
                chk("R4 periph_clk", int'(periph_clk_en), int'(exp != 0));
                chk("R4 slow", int'(slow_clk_sel), int'(exp == 2));
                repeat (2) @(negedge clk);
                chk("R3 persist", int'(mode_o), exp);
            end
        end

        // R5 R6 R7: wake pins, polarity, direction, enable, gie
        for (int pin = 0; pin < P7W; pin++)
          for (int pol = 0; pol < 2; pol++)
            for (int rise = 0; rise < 2; rise++)
              for (int en = 0; en < 2; en++)
                for (int g = 0; g < 2; g++) begin
                    int match, exp;
                    do_reset();
                    p7_rise_sel = 1'(pol);
                    p7_pins[pin] = rise ? 1'b0 : 1'b1;
                    repeat (5) @(negedge clk);
                    gie = 1'(g);
                    p7_wake_en = '0;
                    p7_wake_en[pin] = 1'(en);
                    p7_pins[pin] = rise ? 1'b1 : 1'b0;
                    observe(6);
                    match = (pin == 0) ? int'(pol == rise) : int'(rise == 0);
                    exp = en & g & match;
                    chk("R5 R6 p7 irq count", irq_n, exp);
                    if (exp == 1) chk("R5 latency", irq_at, 3);
                    chk("R7 mode kept", int'(mode_o), 3);
                end

        // R5 R6: port group, falling only
        for (int b = 0; b < P9W; b++)
          for (int en = 0; en < 2; en++)
            for (int rise = 0; rise < 2; rise++) begin
                do_reset();
                p9_wake_en = 1'(en);
                if (rise) begin
                    p9_pins[b] = 1'b0;
                    repeat (5) @(negedge clk);
                end
                gie = 1'b1;
                p9_pins[b] = rise ? 1'b1 : 1'b0;
                observe(6);
                chk("R5 R6 p9 irq count", irq_n, en & int'(rise == 0));
            end

        // R7: timer in run modes
        for (int m = 0; m < 2; m++)
          for (int g = 0; g < 2; g++) begin
              do_reset();
              enter({1'b0, 1'(m)}, 1'b0);
              gie = 1'(g);
              tmr_ovf = 1'b1;
              observe(3);
              chk("R7 tmr irq", irq_n, g);
              if (g == 1) chk("R7 tmr latency", irq_at, 1);
              chk("R7 mode", int'(mode_o), m ? 3 : 2);
              chk("R7 no rst", rst_cnt, 0);
          end

        // R8 R11: watchdog in run modes
        for (int m = 0; m < 2; m++)
          for (int wen = 0; wen < 2; wen++) begin
              do_reset();
              enter({1'b0, 1'(m)}, 1'b0);
              wdt_en = 1'(wen);
              wdt_tmo = 1'b1;
              observe(1);
              chk(wen ? "R8 rst" : "R11 rst", rst_cnt, wen);
              chk("R8 mode", int'(mode_o), (wen == 1) ? 3 : (m ? 3 : 2));
          end

        // R9 R11 R12: idle wake sweep
        for (int src = 0; src < 3; src++)
          for (int g = 0; g < 2; g++)
            for (int wen = 0; wen < 2; wen++)
              for (int s0 = 0; s0 < 2; s0++) begin
                  int wake;
                  do_reset();
                  gie = 1'(g); wdt_en = 1'(wen); p9_wake_en = 1'b1;
                  enter(2'b10, 1'b1);
                  chk("R3 idle entry", int'(mode_o), 1);
                  mode_sel = {1'b1, 1'(s0)};
                  if (src == 0) tmr_ovf = 1'b1;
                  else if (src == 1) p9_pins[0] = 1'b0;
                  else wdt_tmo = 1'b1;
                  observe(6);
                  wake = int'(src == 0) | (int'(src == 1) & g) | (int'(src == 2) & wen);
                  chk((src == 2 && wen == 0) ? "R11 idle" : "R9 idle mode",
                      int'(mode_o), wake ? (s0 ? 3 : 2) : 1);
                  chk("R9 idle irq", irq_n, wake & g & int'(src != 2));
                  chk("R9 idle no rst", rst_cnt, 0);
                  chk("R12 excl", both, 0);
              end

        // R10 R11 R4: sleep wake sweep
        for (int src = 0; src < 3; src++)
          for (int g = 0; g < 2; g++)
            for (int wen = 0; wen < 2; wen++) begin
                int rs;
                do_reset();
                gie = 1'(g); wdt_en = 1'(wen); p9_wake_en = 1'b1;
                enter(2'b00, 1'b1);
                chk("R4 sleep cpu_clk", int'(cpu_clk_en), 0);
                chk("R4 sleep periph_clk", int'(periph_clk_en), 0);
                if (src == 0) tmr_ovf = 1'b1;
                else if (src == 1) p9_pins[0] = 1'b0;
                else wdt_tmo = 1'b1;
                observe(6);
                rs = (int'(src == 1) & g) | (int'(src == 2) & wen);
                chk((src == 2 && wen == 0) ? "R11 sleep rst" : "R10 sleep rst", rst_cnt, rs);
                if (rs == 1) chk("R10 rst mode", rst_mode, 3);
                chk("R10 sleep final mode", int'(mode_o), rs ? 2 : 0);
                chk("R10 no irq", irq_n, 0);
            end

        // R12: coincident timer and watchdog
        do_reset();
        gie = 1'b1; wdt_en = 1'b1;
        tmr_ovf = 1'b1; wdt_tmo = 1'b1;
        observe(2);
        chk("R12 rst wins", rst_cnt, 1);
        chk("R12 no irq", irq_n, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule